// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block holds a 64-bit signed accumulator. Each clock it can take two 32-bit operands and add their signed product to the accumulator, subtract that product from it, or return a scaled window of it while clearing it. Every operation finishes in the cycle it is issued, so the unit has no busy state and operations can be issued back to back.

Software sees the accumulator as two 32-bit special registers, an upper half and a lower half. Both halves are always visible on output ports. Each half can also be loaded directly through a write strobe that carries its own data. The read-and-clear operation returns accumulator bits [59:28] in the same cycle, which is the accumulator arithmetically shifted right by 28 and cut to 32 bits.

Top module: `mac_accum_unit`

## Requirements
- R1: While reset is asserted and after it is released, both accumulator halves read zero until an operation or a write changes them.
- R2: With opSel = 2'b01 (accumulate), the 64-bit accumulator {accHi, accLo} becomes the old value plus the full signed 64-bit product of opA and opB after the next rising edge.
- R3: With opSel = 2'b10 (subtract), the accumulator becomes the old value minus the signed 64-bit product of opA and opB after the next rising edge.
- R4: With opSel = 2'b11 (read-and-clear), macResult shows accumulator bits [59:28] in that same cycle, and both halves read zero after the next rising edge.
- R5: Accumulator arithmetic wraps modulo 2^64, with no saturation and no overflow flag.
- R6: When sprWrHi is set, accHi takes sprWrData after the next edge. When sprWrLo is set, accLo takes sprWrData after the next edge. A half that is not written and has no operation applied keeps its value.
- R7: A special-register write to a half overrides any operation issued in the same cycle for that half only. The other half takes the operation's result.
- R8: With opSel = 2'b00 (idle) and no writes, both halves hold their value whatever opA and opB carry.
- R9: macResult is zero in every cycle where opSel is not read-and-clear.
- R10: Operations issued on consecutive cycles each take effect. Each one starts from the value left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opSel | input | 2 | Operation: 00 idle, 01 accumulate, 10 subtract, 11 read-and-clear |
| opA | input | 32 | First signed operand |
| opB | input | 32 | Second signed operand |
| sprWrHi | input | 1 | Load the upper half from sprWrData |
| sprWrLo | input | 1 | Load the lower half from sprWrData |
| sprWrData | input | 32 | Data for special-register writes |
| macResult | output | 32 | Bits [59:28] of the accumulator during read-and-clear, else zero |
| accHi | output | 32 | Upper accumulator half |
| accLo | output | 32 | Lower accumulator half |

## Verification
Both halves are registered outputs, so a wrong sum, a lost carry between the halves, or a misplaced write priority shows up on accHi and accLo one edge after the operation that caused it. A fault in the read-and-clear path shows up on macResult in the issuing cycle, before the edge. A failed clear shows up one cycle later as a non-zero accumulator. Because each operation builds on the last, a single wrong value also spoils every later expected value in a chain. Carry and sign faults are therefore exposed quickly, even when they only affect one half.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_ACC   = 2'b01,
    OP_SUB   = 2'b10,
    OP_RDCLR = 2'b11
  } macOp_t;

  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doClear;
    logic wrHi;
    logic wrLo;
  } macStrobes_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  opSel,
  input  logic        sprWrHi,
  input  logic        sprWrLo,
  output macStrobes_t strobes
);

  macOp_t opDec;

  always_comb begin
    opDec = macOp_t'(opSel);
    strobes = '0;
    unique case (opDec)
      OP_ACC:   strobes.doAdd   = 1'b1;
      OP_SUB:   strobes.doSub   = 1'b1;
      OP_RDCLR: strobes.doClear = 1'b1;
      default:  ;
    endcase
    strobes.wrHi = sprWrHi;
    strobes.wrLo = sprWrLo;
  end

  // R10: at most one arithmetic action per cycle
  a_r10_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.doAdd, strobes.doSub, strobes.doClear}));

  // R8: idle select raises no strobe
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'b00) |-> !(strobes.doAdd || strobes.doSub || strobes.doClear));

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_R = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  macStrobes_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] accHi,
  output logic [DATA_W-1:0] accLo
);

  localparam int ACC_W  = 2 * DATA_W;
  localparam int N_HALF = 2;

  logic [DATA_W-1:0] halfReg [N_HALF];
  logic [ACC_W-1:0]  accNow;
  logic [ACC_W-1:0]  aExt;
  logic [ACC_W-1:0]  bExt;
  logic [ACC_W-1:0]  product;
  logic [ACC_W-1:0]  accNext;
  logic              opActive;
  logic [N_HALF-1:0] halfWr;

  assign accNow   = {halfReg[1], halfReg[0]};
  assign aExt     = {{DATA_W{opA[DATA_W-1]}}, opA};
  assign bExt     = {{DATA_W{opB[DATA_W-1]}}, opB};
  assign product  = aExt * bExt;
  assign opActive = strobes.doAdd | strobes.doSub | strobes.doClear;
  assign halfWr   = {strobes.wrHi, strobes.wrLo};

  always_comb begin
    if (strobes.doClear)      accNext = '0;
    else if (strobes.doSub)   accNext = accNow - product;
    else                      accNext = accNow + product;
  end

  assign result = strobes.doClear ? accNow[SHIFT_R +: DATA_W] : '0;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rstN)             halfReg[h] <= '0;
      else if (halfWr[h])    halfReg[h] <= wrData;
      else if (opActive)     halfReg[h] <= accNext[h*DATA_W +: DATA_W];
    end
  end

  assign accHi = halfReg[1];
  assign accLo = halfReg[0];

  // R4: read-and-clear with no writes leaves zero behind
  a_r4_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doClear && !strobes.wrHi && !strobes.wrLo) |=> (accHi == '0 && accLo == '0));

  // R2: accumulate adds the signed product
  a_r2_accumulate: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doAdd && !strobes.wrHi && !strobes.wrLo) |=>
      ({accHi, accLo} == $past(accNow) + $past(aExt) * $past(bExt)));

  // R3: subtract removes the signed product
  a_r3_subtract: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doSub && !strobes.wrHi && !strobes.wrLo) |=>
      ({accHi, accLo} == $past(accNow) - $past(aExt) * $past(bExt)));

  // R6, R7: a write to the upper half wins
  a_r6_write_hi: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHi |=> (accHi == $past(wrData)));

  // R6, R7: a write to the lower half wins
  a_r7_write_lo: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLo |=> (accLo == $past(wrData)));

  // R8: nothing issued means nothing changes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!opActive && !strobes.wrHi && !strobes.wrLo) |=> ($stable(accHi) && $stable(accLo)));

  // R9: result stays zero outside read-and-clear
  a_r9_result_zero: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doClear |-> (result == '0));

endmodule

// File: rtl/mac_accum_unit.sv
module mac_accum_unit
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_R = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              sprWrHi,
  input  logic              sprWrLo,
  input  logic [DATA_W-1:0] sprWrData,
  output logic [DATA_W-1:0] macResult,
  output logic [DATA_W-1:0] accHi,
  output logic [DATA_W-1:0] accLo
);

  macStrobes_t strobes;

  mac_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opSel   (opSel),
    .sprWrHi (sprWrHi),
    .sprWrLo (sprWrLo),
    .strobes (strobes)
  );

  mac_datapath #(
    .DATA_W  (DATA_W),
    .SHIFT_R (SHIFT_R)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .wrData  (sprWrData),
    .result  (macResult),
    .accHi   (accHi),
    .accLo   (accLo)
  );

  // R1: reset empties the accumulator
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(!rstN) |-> (accHi == '0 && accLo == '0));

endmodule

// File: tb/mac_accum_unit_test.sv
module mac_accum_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        sprWrHi = 1'b0;
  logic        sprWrLo = 1'b0;
  logic [31:0] sprWrData = '0;
  logic [31:0] macResult;
  logic [31:0] accHi;
  logic [31:0] accLo;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mac_accum_unit uut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opA(opA), .opB(opB),
    .sprWrHi(sprWrHi), .sprWrLo(sprWrLo), .sprWrData(sprWrData),
    .macResult(macResult), .accHi(accHi), .accLo(accLo)
  );

  // opSel, opA, opB, expected result in-cycle, expected hi, expected lo
  localparam int NVEC = 9;
  localparam logic [161:0] VEC [NVEC] = '{
    {2'b01, 32'h00000003, 32'h00000005, 32'h00000000, 32'h00000000, 32'h0000000F},
    {2'b01, 32'hFFFFFFFE, 32'h00000007, 32'h00000000, 32'h00000000, 32'h00000001},
    {2'b10, 32'h00000004, 32'h00000004, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFF1},
    {2'b01, 32'h00010000, 32'h00010000, 32'h00000000, 32'h00000000, 32'hFFFFFFF1},
    {2'b01, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h00000000, 32'h3FFFFFFF, 32'hFFFFFFF2},
    {2'b11, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'h00000000},
    {2'b10, 32'h80000000, 32'h80000000, 32'h00000000, 32'hC0000000, 32'h00000000},
    {2'b10, 32'h80000000, 32'h7FFFFFFF, 32'h00000000, 32'hFFFFFFFF, 32'h80000000},
    {2'b11, 32'h00000000, 32'h00000000, 32'hFFFFFFF8, 32'h00000000, 32'h00000000}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, check result before the edge, check halves after it
  task automatic step(input logic [1:0] sel, input logic [31:0] a, input logic [31:0] b,
                      input logic wh, input logic wl, input logic [31:0] wd,
                      input string req, input logic [31:0] expRes,
                      input logic [31:0] expHi, input logic [31:0] expLo);
    @(negedge clk);
    opSel = sel; opA = a; opB = b; sprWrHi = wh; sprWrLo = wl; sprWrData = wd;
    #1;
    check(req, "macResult", macResult, expRes);
    @(posedge clk);
    #1;
    check(req, "accHi", accHi, expHi);
    check(req, "accLo", accLo, expLo);
    @(negedge clk);
    opSel = 2'b00; sprWrHi = 1'b0; sprWrLo = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "accHi in reset", accHi, 32'h0);
    check("R1", "accLo in reset", accLo, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R9", "macResult idle", macResult, 32'h0);

    // R2 R3 R4 R10: back-to-back chain from the table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      opSel = VEC[i][161:160]; opA = VEC[i][159:128]; opB = VEC[i][127:96];
      #1;
      check(VEC[i][161:160] == 2'b11 ? "R4" : "R9", "macResult", macResult, VEC[i][95:64]);
      @(posedge clk);
      #1;
      check(VEC[i][161:160] == 2'b10 ? "R3" : (VEC[i][161:160] == 2'b11 ? "R4" : "R2"),
            "accHi", accHi, VEC[i][63:32]);
      check("R10", "accLo", accLo, VEC[i][31:0]);
    end

    // R6: upper-half write alone, lower untouched
    step(2'b00, 32'h1, 32'h1, 1'b1, 1'b0, 32'h12345678, "R6", 32'h0, 32'h12345678, 32'h0);
    step(2'b00, 32'h0, 32'h0, 1'b0, 1'b1, 32'hFFFFFFFF, "R6", 32'h0, 32'h12345678, 32'hFFFFFFFF);
    // R7: lower write with concurrent accumulate, carry reaches upper half
    step(2'b01, 32'h1, 32'h1, 1'b0, 1'b1, 32'h00000005, "R7", 32'h0, 32'h12345679, 32'h00000005);
    // R7: both writes beat read-and-clear, result still read out
    step(2'b11, 32'h0, 32'h0, 1'b1, 1'b1, 32'hCAFE0000, "R7", 32'h23456790, 32'hCAFE0000, 32'hCAFE0000);
    // R8: idle with busy operands holds
    step(2'b00, 32'h7, 32'h9, 1'b0, 1'b0, 32'h0, "R8", 32'h0, 32'hCAFE0000, 32'hCAFE0000);
    // R5: wrap past 2^64 to zero
    step(2'b00, 32'h0, 32'h0, 1'b1, 1'b1, 32'hFFFFFFFF, "R5", 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    step(2'b01, 32'h1, 32'h1, 1'b0, 1'b0, 32'h0, "R5", 32'h0, 32'h0, 32'h0);
    // R5: no saturation at the signed limit
    step(2'b00, 32'h0, 32'h0, 1'b1, 1'b0, 32'h7FFFFFFF, "R5", 32'h0, 32'h7FFFFFFF, 32'h0);
    step(2'b00, 32'h0, 32'h0, 1'b0, 1'b1, 32'hFFFFFFFF, "R5", 32'h0, 32'h7FFFFFFF, 32'hFFFFFFFF);
    step(2'b01, 32'h1, 32'h1, 1'b0, 1'b0, 32'h0, "R5", 32'h0, 32'h80000000, 32'h0);

    // R1: reset in mid-run clears a non-zero accumulator
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    check("R1", "accHi after reset", accHi, 32'h0);
    check("R1", "accLo after reset", accLo, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule